// File: doc/BRIEF.md
# Over-Temperature Alarm with Consecutive-Fault Filter

This block watches a stream of 10-bit two's complement temperature results, one for each pulse of a valid strobe, with a resolution of 0.25 °C. It compares each result against two 9-bit two's complement thresholds with a resolution of 0.5 °C. One threshold is the trip level and the other is the release (hysteresis) level. A result only changes the block's internal hot/cool state after a programmable number of consecutive out-of-limit results, so a single noisy sample cannot toggle the output.

The alarm pin works in one of two modes. In level-following (comparator) mode it mirrors the hot/cool state. In event (interrupt) mode it latches when the block trips and stays latched until a clear pulse. The clear pulse stands for software reading the alarm source. A polarity input picks whether the active pin level is high or low. Register access and the converter itself live elsewhere; this block sees only the configuration fields, the thresholds and the result stream.

Top module: `ovt_alarm`

## Requirements
- R1: While reset is held and on the first cycle after it, the alarm is inactive (alarm_out equals the inverse of cfg_pol) and the consecutive-fault count is zero.
- R2: The comparison uses result bits [9:1] as a signed 9-bit value. While the block is cool, a result counts as a fault only when that value is strictly greater than set_trip. Equality is not a fault.
- R3: While the block is hot, a result counts as a fault only when its signed bits [9:1] are strictly less than set_rel. Equality is not a fault.
- R4: cfg_qlen sets the number of consecutive faults needed to flip the hot/cool state: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 6. The output reflects the flip in the cycle after the strobe that completes the run.
- R5: A valid result that is not a fault sets the consecutive-fault count back to zero.
- R6: With cfg_irq_mode = 0, the logical alarm equals the hot state.
- R7: With cfg_irq_mode = 1, the logical alarm becomes active when a run of faults moves the block from cool to hot. It becomes inactive only in the cycle after an alarm_clr pulse. If a trip and a clear arrive in the same cycle, the trip wins.
- R8: With cfg_irq_mode = 1, once the alarm is cleared while the block is still hot, further over-trip results do not raise it again. It can only fire again after a run of below-release results has returned the block to cool and a new over-trip run has completed. The release run itself does not raise the alarm.
- R9: cfg_pol = 1 makes the active pin level high and cfg_pol = 0 makes it low. A change of cfg_pol acts on alarm_out combinationally.
- R10: In a cycle where cfg_qlen differs from its value in the previous cycle, the count is cleared and a valid result in that cycle is not counted.
- R11: Cycles without res_valid leave the hot state and the count unchanged. alarm_clr has no effect in comparator mode.
- R12: While cfg_irq_mode = 0, any latched interrupt is dropped, so returning to event mode starts with the alarm inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_qlen | input | 2 | Consecutive-fault run length code |
| cfg_pol | input | 1 | 1 = alarm active high, 0 = active low |
| cfg_irq_mode | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| set_trip | input | 9 | Trip threshold, signed, 0.5 °C per LSB |
| set_rel | input | 9 | Release threshold, signed, 0.5 °C per LSB |
| res_valid | input | 1 | New temperature result strobe |
| res_temp | input | 10 | Temperature result, signed, 0.25 °C per LSB |
| alarm_clr | input | 1 | Clears a latched interrupt-mode alarm |
| alarm_out | output | 1 | Alarm pin |

## Verification
The bench places results exactly on each threshold and one half-degree past it. A design that compared with >= instead of > would trip or release one step early. It runs a six-deep queue with an interruption one result short of completion, which catches an off-by-one depth or a counter that fails to clear. It changes the queue code in the middle of a run, which would expose a design that keeps the stale count. In event mode it clears while the block is still hot, and a design that re-armed immediately would refire on the next hot result. It also lands a clear on the cycle of a trip, and a design with the wrong priority would lose the event.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

    localparam int TEMP_W = 10;
    localparam int SET_W  = 9;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        QLEN_ONE  = 2'b00,
        QLEN_TWO  = 2'b01,
        QLEN_FOUR = 2'b10,
        QLEN_SIX  = 2'b11
    } qlen_e;

    typedef enum logic [1:0] {
        EVT_NONE    = 2'b00,
        EVT_TRIP    = 2'b01,
        EVT_RELEASE = 2'b10
    } qevt_e;

    typedef struct packed {
        logic over_trip;
        logic under_rel;
    } cmp_t;

    function automatic logic [CNT_W-1:0] run_depth(input logic [1:0] code);
        case (qlen_e'(code))
            QLEN_ONE:  return CNT_W'(1);
            QLEN_TWO:  return CNT_W'(2);
            QLEN_FOUR: return CNT_W'(4);
            default:   return CNT_W'(6);
        endcase
    endfunction

endpackage

// File: rtl/ovt_classify.sv
module ovt_classify
    import ovt_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int SW = SET_W
) (
    input  logic [TW-1:0] temp,
    input  logic [SW-1:0] trip_lvl,
    input  logic [SW-1:0] rel_lvl,
    output cmp_t          cmp
);
    localparam int DROP = TW - SW;

    logic signed [SW-1:0] coarse;

    assign coarse        = $signed(temp[TW-1:DROP]);
    assign cmp.over_trip = coarse > $signed(trip_lvl);
    assign cmp.under_rel = coarse < $signed(rel_lvl);
endmodule

// File: rtl/ovt_fault_queue.sv
module ovt_fault_queue
    import ovt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  cmp_t          cmp,
    input  logic [1:0]    qlen,
    output logic          hot,
    output qevt_e         evt,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;
    logic          hot_q;
    logic [1:0]    qlen_prev;
    logic          qlen_moved;
    logic          is_fault;
    logic          run_done;

    assign qlen_moved = qlen != qlen_prev;
    assign is_fault   = hot_q ? cmp.under_rel : cmp.over_trip;
    assign run_done   = valid && !qlen_moved && is_fault
                        && (cnt_q + CW'(1) == run_depth(qlen));

    always_comb begin
        evt = EVT_NONE;
        if (run_done) evt = hot_q ? EVT_RELEASE : EVT_TRIP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            hot_q     <= 1'b0;
            qlen_prev <= qlen;
        end else begin
            qlen_prev <= qlen;
            if (qlen_moved) begin
                cnt_q <= '0;
            end else if (valid) begin
                if (run_done) begin
                    cnt_q <= '0;
                    hot_q <= ~hot_q;
                end else if (is_fault) begin
                    cnt_q <= cnt_q + CW'(1);
                end else begin
                    cnt_q <= '0;
                end
            end
        end
    end

    assign hot = hot_q;
    assign cnt = cnt_q;
endmodule

// File: rtl/ovt_alarm_drive.sv
module ovt_alarm_drive
    import ovt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  qevt_e evt,
    input  logic  hot,
    input  logic  irq_mode,
    input  logic  pol,
    input  logic  clr,
    output logic  pin
);
    logic pend_q;
    logic level;

    always_ff @(posedge clk) begin
        if (rst || !irq_mode) pend_q <= 1'b0;
        else if (evt == EVT_TRIP) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign level = irq_mode ? pend_q : hot;
    assign pin   = pol ? level : ~level;
endmodule

// File: rtl/ovt_alarm.sv
module ovt_alarm
    import ovt_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int SW = SET_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_qlen,
    input  logic          cfg_pol,
    input  logic          cfg_irq_mode,
    input  logic [SW-1:0] set_trip,
    input  logic [SW-1:0] set_rel,
    input  logic          res_valid,
    input  logic [TW-1:0] res_temp,
    input  logic          alarm_clr,
    output logic          alarm_out
);
    cmp_t          cmp;
    logic          hot;
    qevt_e         evt;
    logic [CW-1:0] q_cnt;

    ovt_classify #(.TW(TW), .SW(SW)) u_classify (
        .temp     (res_temp),
        .trip_lvl (set_trip),
        .rel_lvl  (set_rel),
        .cmp      (cmp)
    );

    ovt_fault_queue #(.CW(CW)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .valid (res_valid),
        .cmp   (cmp),
        .qlen  (cfg_qlen),
        .hot   (hot),
        .evt   (evt),
        .cnt   (q_cnt)
    );

    ovt_alarm_drive u_drive (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .hot      (hot),
        .irq_mode (cfg_irq_mode),
        .pol      (cfg_pol),
        .clr      (alarm_clr),
        .pin      (alarm_out)
    );
endmodule

// File: rtl/ovt_alarm_chk.sv
module ovt_alarm_chk
    import ovt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cfg_qlen,
    input logic          cfg_pol,
    input logic          cfg_irq_mode,
    input logic          res_valid,
    input logic          alarm_clr,
    input logic          alarm_out,
    input logic [CW-1:0] fault_cnt
);
    logic act;
    assign act = cfg_pol ? alarm_out : ~alarm_out;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (alarm_out == !cfg_pol && fault_cnt == '0)); // R1

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_qlen) |-> fault_cnt < run_depth(cfg_qlen)); // R4

    AST_CMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(res_valid) && !cfg_irq_mode && $stable(cfg_irq_mode)
         && $stable(cfg_pol)) |-> $stable(alarm_out)); // R11

    AST_IRQ_RISE_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        (cfg_irq_mode && $stable(cfg_irq_mode) && $stable(cfg_pol) && $rose(act))
        |-> $past(res_valid)); // R7

    AST_IRQ_FALL_ON_CLR: assert property (@(posedge clk) disable iff (rst)
        (cfg_irq_mode && $stable(cfg_irq_mode) && $stable(cfg_pol) && $fell(act))
        |-> $past(alarm_clr)); // R7

    AST_POL_FLIP: assert property (@(posedge clk) disable iff (rst)
        (cfg_pol != $past(cfg_pol) && !$past(res_valid) && !$past(alarm_clr)
         && $stable(cfg_irq_mode)) |-> alarm_out != $past(alarm_out)); // R9
endmodule

bind ovt_alarm ovt_alarm_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_qlen     (cfg_qlen),
    .cfg_pol      (cfg_pol),
    .cfg_irq_mode (cfg_irq_mode),
    .res_valid    (res_valid),
    .alarm_clr    (alarm_clr),
    .alarm_out    (alarm_out),
    .fault_cnt    (q_cnt)
);

// File: tb/ovt_alarm_bench.sv
module ovt_alarm_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_qlen = 2'b00;
    logic       cfg_pol = 1'b1;
    logic       cfg_irq_mode = 1'b0;
    logic [8:0] set_trip = 9'd100;
    logic [8:0] set_rel = 9'd80;
    logic       res_valid = 1'b0;
    logic [9:0] res_temp = '0;
    logic       alarm_clr = 1'b0;
    logic       alarm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    bit       m_hot = 0;
    bit       m_pend = 0;
    int       m_cnt = 0;
    bit [1:0] m_qprev = 2'b00;

    always #4 clk = ~clk;

    ovt_alarm u_ovt_alarm (
        .clk(clk), .rst(rst), .cfg_qlen(cfg_qlen), .cfg_pol(cfg_pol),
        .cfg_irq_mode(cfg_irq_mode), .set_trip(set_trip), .set_rel(set_rel),
        .res_valid(res_valid), .res_temp(res_temp), .alarm_clr(alarm_clr),
        .alarm_out(alarm_out)
    );

    function automatic int depth_of(input bit [1:0] c);
        case (c)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    function automatic bit expect_pin();
        bit lvl;
        lvl = cfg_irq_mode ? m_pend : m_hot;
        return cfg_pol ? lvl : !lvl;
    endfunction

    task automatic model_step();
        bit qchg;
        bit flt;
        bit trip;
        int t9;
        trip = 0;
        if (rst) begin
            m_hot = 0; m_pend = 0; m_cnt = 0; m_qprev = cfg_qlen;
            return;
        end
        qchg = cfg_qlen != m_qprev;
        m_qprev = cfg_qlen;
        if (qchg) m_cnt = 0;
        else if (res_valid) begin
            t9 = int'($signed(res_temp)) >>> 1;
            flt = m_hot ? (t9 < int'($signed(set_rel))) : (t9 > int'($signed(set_trip)));
            if (flt) begin
                if (m_cnt + 1 == depth_of(cfg_qlen)) begin
                    trip = !m_hot;
                    m_hot = !m_hot;
                    m_cnt = 0;
                end else m_cnt++;
            end else m_cnt = 0;
        end
        if (!cfg_irq_mode) m_pend = 0;
        else if (trip) m_pend = 1;
        else if (alarm_clr) m_pend = 0;
    endtask

    task automatic check(input string tag);
        bit exp;
        exp = expect_pin();
        n_chk++;
        if (alarm_out !== exp) begin
            n_fail++;
            $display("FAIL %s alarm_out actual=%b expected=%b t=%0t", tag, alarm_out, exp, $time);
        end
    endtask

    // called at a falling edge; drives, advances model, checks at next falling edge
    task automatic step(input bit v, input int q, input bit clr, input string tag);
        res_valid = v;
        res_temp  = 10'(q);
        alarm_clr = clr;
        model_step();
        @(negedge clk);
        check(tag);
        res_valid = 0;
        alarm_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        model_step();
        repeat (2) @(negedge clk);
        check("R1");
        rst = 0;
        step(0, 0, 0, "R1");

        // thresholds: trip 50.0 C (100), release 40.0 C (80); temp in quarter degrees
        step(1, 200, 0, "R2");   // equal to trip -> no fault
        step(1, 201, 0, "R2");   // still 100 after drop of LSB
        step(1, 202, 0, "R2");   // 101 > 100 -> trip (depth 1)
        step(0, 0, 1, "R11");    // clear ignored in comparator mode
        step(1, 160, 0, "R3");   // equal to release -> stays hot
        step(1, 158, 0, "R3");   // 79 < 80 -> release

        // depth 6, run broken one short
        cfg_qlen = 2'b11;
        step(0, 0, 0, "R10");
        for (int i = 0; i < 5; i++) step(1, 300, 0, "R4");
        step(1, 100, 0, "R5");
        for (int i = 0; i < 5; i++) step(1, 300, 0, "R5");
        step(1, 300, 0, "R4");   // sixth consecutive -> hot

        // change queue code mid run while hot
        cfg_qlen = 2'b10;
        step(0, 0, 0, "R10");
        for (int i = 0; i < 3; i++) step(1, 50, 0, "R10");
        cfg_qlen = 2'b01;
        step(1, 50, 0, "R10");   // not counted
        step(1, 50, 0, "R10");   // count 1 of 2
        step(1, 50, 0, "R10");   // release

        // polarity flip, negative thresholds, interrupt mode
        cfg_pol = 0;
        step(0, 0, 0, "R9");
        cfg_qlen = 2'b00;
        set_trip = 9'h1EC;       // -10.0 C
        set_rel  = 9'h1D8;       // -20.0 C
        cfg_irq_mode = 1;
        step(0, 0, 0, "R12");
        step(1, 10'h3D8, 0, "R2");  // -10.0 C equal -> nothing
        step(1, 10'h3DA, 1, "R7");  // -9.5 C trips, clear same cycle loses
        step(1, 10'h3FF, 0, "R7");  // hot already, held
        step(0, 0, 1, "R7");        // cleared
        step(1, 10'h100, 0, "R8");  // still hot, no refire
        step(1, 10'h3A0, 0, "R8");  // -24 C release, no event
        step(1, 10'h100, 0, "R8");  // trips again
        cfg_irq_mode = 0;
        step(0, 0, 0, "R12");
        cfg_irq_mode = 1;
        step(0, 0, 0, "R12");
        cfg_pol = 1;
        step(0, 0, 0, "R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 40) == 0) cfg_qlen = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 80) == 0) cfg_irq_mode = ~cfg_irq_mode;
            if ($urandom_range(0, 80) == 0) cfg_pol = ~cfg_pol;
            step($urandom_range(0, 9) < 7,
                 int'($signed(set_trip)) * 2 + int'($urandom_range(0, 40)) - 30,
                 $urandom_range(0, 9) == 0, "R6");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule